// File: doc/BRIEF.md
# Temperature Lookup-Table Fan Controller

This block turns one zone temperature into an 8-bit fan duty cycle. The duty comes from a thirteen-step table. Step 1 starts at a programmable base temperature. Each of steps 2 to 13 starts at that base plus its own programmable offset. Every step carries its own duty value. A minimum duty is a floor for the table output. A hysteresis band keeps the table from dropping back as soon as the temperature dips below a step's threshold.

The table result can be merged with a duty requested by a separate proportional/integral loop. When that loop is enabled, the larger of the two requests wins. Above everything sits a boost override. A temperature strictly above the boost limit forces full duty (255). Boost releases only when the temperature falls below the limit minus a programmable boost hysteresis.

Temperatures are signed two's complement with an LSb of 0.5 °C. A coarse mode rounds the control temperature down to whole degrees before any comparison. The duty is registered, so a change of input shows at the output one clock later.

Top module: `lut_fan_ctrl`

## Requirements
- R1: While reset is asserted, `duty_out` is 0, the table sits below step 1, and boost is off.
- R2: The threshold of step k is `base_temp` plus the offset of step k. Step 1 has a zero offset, and the offset of step k (k = 2..13) is `step_off[(k-2)*8 +: 8]`, unsigned, in 0.5 °C units. The sum saturates at +255 and never wraps. The table rises at once to the highest step whose threshold is less than or equal to the temperature.
- R3: At step k the table duty is the larger of `step_duty[(k-1)*8 +: 8]` and `min_duty`. Below step 1 the table duty is `min_duty`.
- R4: The table leaves its current step only when the temperature is below that step's threshold minus `hyst`. It then lands on the highest step whose lowered threshold (threshold minus `hyst`, saturated at -256) the temperature still reaches, and never lower than the rise rule of R2 gives.
- R5: With `pi_en` = 1 the output is the larger of the table duty and `pi_duty`. With `pi_en` = 0, `pi_duty` has no effect.
- R6: A temperature strictly greater than `boost_lim` forces `duty_out` to 255. Boost stays on until the temperature is below `boost_lim` minus `boost_hyst` (saturated at -256).
- R7: With `coarse_en` = 1, bit 0 of the temperature is cleared before every table and boost comparison.
- R8: `duty_out` is a register. It reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_in | input | 9 | Zone temperature, signed, 0.5 °C per LSb |
| coarse_en | input | 1 | Round control temperature down to 1 °C |
| base_temp | input | 9 | Step-1 threshold, signed |
| step_off | input | 96 | Offsets of steps 2..13, 8 bits each, unsigned |
| step_duty | input | 104 | Duty of steps 1..13, 8 bits each |
| min_duty | input | 8 | Table duty floor |
| hyst | input | 5 | Falling hysteresis of table steps, 0.5 °C units |
| boost_lim | input | 9 | Boost limit, signed |
| boost_hyst | input | 5 | Boost release hysteresis, 0.5 °C units |
| pi_en | input | 1 | Merge the loop-controller request |
| pi_duty | input | 8 | Duty requested by the loop controller |
| duty_out | output | 8 | Fan duty cycle |

## Verification
The temperature is first walked up across several thresholds, so that immediate multi-step rises show up. It is then nudged downward inside the hysteresis band and then just past it. This separates a correct hold from a premature or overlong drop. A base near the top of the range detects wrapping threshold arithmetic, and an odd temperature next to the boost limit tells the coarse mode apart from the fine mode. A long random phase then varies every input, including unordered offsets and wide hysteresis. It is compared on every clock against a behavioural model, which exercises the merge with the loop request and the boost entry and release against each other.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int LFC_TW    = 9;
  localparam int LFC_OW    = 8;
  localparam int LFC_HW    = 5;
  localparam int LFC_DW    = 8;
  localparam int LFC_NSTEP = 13;

  // Clamp a value into the range of a w-bit signed number.
  function automatic int clamp_s(input int v, input int w);
    int lo;
    int hi;
    lo = -(1 <<< (w - 1));
    hi = (1 <<< (w - 1)) - 1;
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/lfc_thresh.sv
module lfc_thresh #(
  parameter int TW    = lfc_pkg::LFC_TW,
  parameter int OW    = lfc_pkg::LFC_OW,
  parameter int HW    = lfc_pkg::LFC_HW,
  parameter int NSTEP = lfc_pkg::LFC_NSTEP
) (
  input  logic signed [TW-1:0]         base_temp,
  input  logic [(NSTEP-1)*OW-1:0]      step_off,
  input  logic [HW-1:0]                hyst,
  output logic [NSTEP*TW-1:0]          th_up,
  output logic [NSTEP*TW-1:0]          th_dn
);
  import lfc_pkg::*;

  for (genvar k = 0; k < NSTEP; k++) begin : g_step
    int ofs;
    int up;
    if (k == 0) begin : g_first
      assign ofs = 0;
    end else begin : g_rest
      assign ofs = int'({1'b0, step_off[(k-1)*OW +: OW]});
    end
    assign up = clamp_s(int'(base_temp) + ofs, TW);
    assign th_up[k*TW +: TW] = TW'(up);
    assign th_dn[k*TW +: TW] = TW'(clamp_s(up - int'({1'b0, hyst}), TW));
  end
endmodule

// File: rtl/lfc_level.sv
module lfc_level #(
  parameter int TW    = lfc_pkg::LFC_TW,
  parameter int NSTEP = lfc_pkg::LFC_NSTEP,
  localparam int LW   = $clog2(NSTEP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [TW-1:0] t_ctl,
  input  logic [NSTEP*TW-1:0]  th_up,
  input  logic [NSTEP*TW-1:0]  th_dn,
  output logic [LW-1:0]        up_lvl,
  output logic [LW-1:0]        hold_lvl,
  output logic [LW-1:0]        level_n,
  output logic [LW-1:0]        level_q
);
  import lfc_pkg::*;

  always_comb begin
    up_lvl   = '0;
    hold_lvl = '0;
    for (int k = 0; k < NSTEP; k++) begin
      if (t_ctl >= $signed(th_up[k*TW +: TW])) up_lvl   = LW'(k + 1);
      if (t_ctl >= $signed(th_dn[k*TW +: TW])) hold_lvl = LW'(k + 1);
    end
    level_n = LW'(imax(int'(up_lvl), imin(int'(level_q), int'(hold_lvl))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_n;
  end
endmodule

// File: rtl/lfc_boost.sv
module lfc_boost #(
  parameter int TW = lfc_pkg::LFC_TW,
  parameter int HW = lfc_pkg::LFC_HW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [TW-1:0] t_ctl,
  input  logic signed [TW-1:0] boost_lim,
  input  logic [HW-1:0]        boost_hyst,
  output logic                 boost_n,
  output logic                 boost_q
);
  import lfc_pkg::*;

  logic signed [TW-1:0] rel_lim;

  assign rel_lim = TW'(clamp_s(int'(boost_lim) - int'({1'b0, boost_hyst}), TW));
  assign boost_n = boost_q ? !(t_ctl < rel_lim) : (t_ctl > boost_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boost_q <= 1'b0;
    else        boost_q <= boost_n;
  end
endmodule

// File: rtl/lut_fan_ctrl.sv
module lut_fan_ctrl #(
  parameter int TW    = lfc_pkg::LFC_TW,
  parameter int OW    = lfc_pkg::LFC_OW,
  parameter int HW    = lfc_pkg::LFC_HW,
  parameter int DW    = lfc_pkg::LFC_DW,
  parameter int NSTEP = lfc_pkg::LFC_NSTEP
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TW-1:0]     temp_in,
  input  logic                     coarse_en,
  input  logic signed [TW-1:0]     base_temp,
  input  logic [(NSTEP-1)*OW-1:0]  step_off,
  input  logic [NSTEP*DW-1:0]      step_duty,
  input  logic [DW-1:0]            min_duty,
  input  logic [HW-1:0]            hyst,
  input  logic signed [TW-1:0]     boost_lim,
  input  logic [HW-1:0]            boost_hyst,
  input  logic                     pi_en,
  input  logic [DW-1:0]            pi_duty,
  output logic [DW-1:0]            duty_out
);
  localparam int LW = $clog2(NSTEP + 1);

  logic signed [TW-1:0] t_ctl;
  logic [NSTEP*TW-1:0]  th_up;
  logic [NSTEP*TW-1:0]  th_dn;
  logic [LW-1:0]        up_lvl;
  logic [LW-1:0]        hold_lvl;
  logic [LW-1:0]        level_n;
  logic [LW-1:0]        level_q;
  logic                 boost_n;
  logic                 boost_q;
  logic [DW-1:0]        step_sel;
  logic [DW-1:0]        tbl_duty;
  logic [DW-1:0]        mix_duty;
  logic [DW-1:0]        duty_d;

  assign t_ctl = coarse_en ? {temp_in[TW-1:1], 1'b0} : temp_in;

  lfc_thresh #(.TW(TW), .OW(OW), .HW(HW), .NSTEP(NSTEP)) u_thresh (
    .base_temp (base_temp),
    .step_off  (step_off),
    .hyst      (hyst),
    .th_up     (th_up),
    .th_dn     (th_dn)
  );

  lfc_level #(.TW(TW), .NSTEP(NSTEP)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .t_ctl    (t_ctl),
    .th_up    (th_up),
    .th_dn    (th_dn),
    .up_lvl   (up_lvl),
    .hold_lvl (hold_lvl),
    .level_n  (level_n),
    .level_q  (level_q)
  );

  lfc_boost #(.TW(TW), .HW(HW)) u_boost (
    .clk        (clk),
    .rst_n      (rst_n),
    .t_ctl      (t_ctl),
    .boost_lim  (boost_lim),
    .boost_hyst (boost_hyst),
    .boost_n    (boost_n),
    .boost_q    (boost_q)
  );

  always_comb begin
    step_sel = '0;
    for (int k = 0; k < NSTEP; k++) begin
      if (level_n == LW'(k + 1)) step_sel = step_duty[k*DW +: DW];
    end
    if (level_n == '0)           tbl_duty = min_duty;
    else if (step_sel > min_duty) tbl_duty = step_sel;
    else                         tbl_duty = min_duty;
    mix_duty = (pi_en && (pi_duty > tbl_duty)) ? pi_duty : tbl_duty;
    duty_d   = boost_n ? '1 : mix_duty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_out <= '0;
    else        duty_out <= duty_d;
  end
endmodule

// File: rtl/lut_fan_ctrl_chk.sv
module lut_fan_ctrl_chk #(
  parameter int DW    = lfc_pkg::LFC_DW,
  parameter int NSTEP = lfc_pkg::LFC_NSTEP,
  localparam int LW   = $clog2(NSTEP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] duty_out,
  input logic [DW-1:0] min_duty,
  input logic          pi_en,
  input logic [DW-1:0] pi_duty,
  input logic [LW-1:0] up_lvl,
  input logic [LW-1:0] hold_lvl,
  input logic [LW-1:0] level_q,
  input logic          boost_q
);
  logic past_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  p_lvl_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(NSTEP));

  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && ($past(up_lvl) > $past(level_q))) |-> (level_q == $past(up_lvl)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && ($past(up_lvl) <= $past(level_q)) && ($past(hold_lvl) >= $past(level_q)))
      |-> (level_q == $past(level_q)));

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && ($past(up_lvl) <= $past(level_q)) && ($past(hold_lvl) < $past(level_q)))
      |-> (level_q == (($past(up_lvl) > $past(hold_lvl)) ? $past(up_lvl) : $past(hold_lvl))));

  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> (duty_out >= $past(min_duty)));

  p_pi_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(pi_en)) |-> (duty_out >= $past(pi_duty)));

  p_boost_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && boost_q) |-> (duty_out == '1));
endmodule

bind lut_fan_ctrl lut_fan_ctrl_chk #(.DW(DW), .NSTEP(NSTEP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .duty_out (duty_out),
  .min_duty (min_duty),
  .pi_en    (pi_en),
  .pi_duty  (pi_duty),
  .up_lvl   (up_lvl),
  .hold_lvl (hold_lvl),
  .level_q  (level_q),
  .boost_q  (boost_q)
);

// File: tb/sim_lut_fan_ctrl.sv
module sim_lut_fan_ctrl;
  localparam int CLK_P = 10;
  localparam int NS    = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [8:0] temp_in = '0;
  logic              coarse_en = 1'b0;
  logic signed [8:0] base_temp = '0;
  logic [95:0]       step_off = '0;
  logic [103:0]      step_duty = '0;
  logic [7:0]        min_duty = '0;
  logic [4:0]        hyst = '0;
  logic signed [8:0] boost_lim = '0;
  logic [4:0]        boost_hyst = '0;
  logic              pi_en = 1'b0;
  logic [7:0]        pi_duty = '0;
  logic [7:0]        duty_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_lvl = 0;
  int m_boost = 0;
  int m_duty = 0;

  always #(CLK_P/2) clk = ~clk;

  lut_fan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .coarse_en(coarse_en),
    .base_temp(base_temp), .step_off(step_off), .step_duty(step_duty),
    .min_duty(min_duty), .hyst(hyst), .boost_lim(boost_lim),
    .boost_hyst(boost_hyst), .pi_en(pi_en), .pi_duty(pi_duty),
    .duty_out(duty_out)
  );

  function automatic int lim9(input int v);
    if (v > 255) return 255;
    if (v < -256) return -256;
    return v;
  endfunction

  function automatic int thr(input int k);
    int extra;
    extra = (k == 1) ? 0 : int'(step_off[(k-2)*8 +: 8]);
    return lim9(int'(base_temp) + extra);
  endfunction

  // Behavioural reference: updates on each rising edge from the sampled inputs.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_boost = 0; m_duty = 0;
    end else begin
      int t, rise, keep, tbl, sd;
      t = int'(temp_in);
      if (coarse_en) t = t & ~1;
      rise = 0; keep = 0;
      for (int k = 1; k <= NS; k++) begin
        if (t >= thr(k)) rise = k;
        if (t >= lim9(thr(k) - int'(hyst))) keep = k;
      end
      if (keep > m_lvl) keep = m_lvl;
      m_lvl = (rise > keep) ? rise : keep;
      if (m_boost != 0) m_boost = (t < lim9(int'(boost_lim) - int'(boost_hyst))) ? 0 : 1;
      else              m_boost = (t > int'(boost_lim)) ? 1 : 0;
      tbl = int'(min_duty);
      if (m_lvl > 0) begin
        sd = int'(step_duty[(m_lvl-1)*8 +: 8]);
        if (sd > tbl) tbl = sd;
      end
      if (pi_en && int'(pi_duty) > tbl) tbl = int'(pi_duty);
      m_duty = (m_boost != 0) ? 255 : tbl;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: duty_out actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock; compare against the model every cycle, away from the edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R8 model", int'(duty_out), m_duty);
  endtask

  task automatic setup(input int base);
    base_temp = 9'(base);
    for (int k = 2; k <= NS; k++) step_off[(k-2)*8 +: 8] = 8'(10 * (k - 1));
    for (int k = 1; k <= NS; k++) step_duty[(k-1)*8 +: 8] = 8'(40 + 15 * k);
    min_duty = 8'd30; hyst = 5'd6; boost_lim = 9'sd200; boost_hyst = 5'd20;
    pi_en = 1'b0; pi_duty = '0; coarse_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    setup(80);
    temp_in = 9'sd100;
    repeat (3) @(negedge clk);
    chk("R1 reset", int'(duty_out), 0);
    rst_n = 1'b1;
    temp_in = 9'sd60;  tick(); chk("R3 below step 1", int'(duty_out), 30);
    temp_in = 9'sd100; tick(); chk("R2 rise to step 3", int'(duty_out), 85);
    temp_in = 9'sd97;  tick(); chk("R4 hold in band", int'(duty_out), 85);
    temp_in = 9'sd93;  tick(); chk("R4 drop past band", int'(duty_out), 70);
    pi_en = 1'b1; pi_duty = 8'd150; tick(); chk("R5 pi larger", int'(duty_out), 150);
    pi_duty = 8'd20;  tick(); chk("R5 table larger", int'(duty_out), 70);
    pi_en = 1'b0; pi_duty = 8'd250; tick(); chk("R5 pi disabled", int'(duty_out), 70);
    min_duty = 8'd100; tick(); chk("R3 floor", int'(duty_out), 100);
    min_duty = 8'd30;
    temp_in = 9'sd201; tick(); chk("R6 boost on", int'(duty_out), 255);
    temp_in = 9'sd185; tick(); chk("R6 boost held", int'(duty_out), 255);
    temp_in = 9'sd179; tick(); chk("R6 boost released", int'(duty_out), 205);
    temp_in = 9'sd150; tick(); chk("R4 fall to step 8", int'(duty_out), 160);
    coarse_en = 1'b1; temp_in = 9'sd201; tick(); chk("R7 coarse no boost", int'(duty_out), 235);
    coarse_en = 1'b0; tick(); chk("R7 fine boost", int'(duty_out), 255);
    setup(250); boost_lim = 9'sd255;
    temp_in = -9'sd256; tick(); chk("R6 release to low", int'(duty_out), 30);
    temp_in = 9'sd252;  tick(); chk("R2 saturated offsets", int'(duty_out), 55);
    temp_in = 9'sd255;  tick(); chk("R2 top of range", int'(duty_out), 235);
    rst_n = 1'b0; @(negedge clk); chk("R1 reset mid-run", int'(duty_out), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        base_temp = 9'($urandom_range(0, 511));
        for (int k = 0; k < 12; k++) step_off[k*8 +: 8] = 8'($urandom_range(0, 255));
        for (int k = 0; k < 13; k++) step_duty[k*8 +: 8] = 8'($urandom_range(0, 255));
        hyst = 5'($urandom_range(0, 31));
        boost_lim = 9'($urandom_range(0, 511));
        boost_hyst = 5'($urandom_range(0, 31));
      end
      if (i % 7 == 0) temp_in = 9'($urandom_range(0, 511));
      else temp_in = 9'(lim9(int'(temp_in) + int'($urandom_range(0, 8)) - 4));
      if (i % 13 == 0) begin
        min_duty = 8'($urandom_range(0, 120));
        pi_en = 1'($urandom_range(0, 1));
        pi_duty = 8'($urandom_range(0, 255));
        coarse_en = 1'($urandom_range(0, 1));
      end
      tick();
    end
    finish_run();
  end
endmodule